// File: doc/BRIEF.md
# Supply-Monitor Write-Protect Controller

This block watches a stream of digitized supply readings, each a millivolt value from an external converter, and decides whether a byte-wide storage array may be accessed, which source feeds that array, and whether the backup cell has ever been brought into service. When the supply leaves its tolerance band, the block blocks writes. It also tells the data drivers to float and tells the access decoder to ignore its inputs. It releases all three only after the supply has climbed back above a higher resume level. A one-bit grade input selects between a tight and a wide tolerance band.

Below the protect band there is a lower switchover level. Under it the array is moved onto the backup cell, but only if that cell has been armed. The cell starts out sealed and is armed for good by the first reading above 4250 mV. If the supply collapses while the cell is still sealed, the array stays on the external rail and a sticky data-lost flag is raised.

Every transition is qualified by a run of consecutive valid samples, and the run length is set at run time. This stops noise near a threshold from making the state chatter.

Top module: `supply_guard`

## Requirements
- R1: After reset the state code is 1 (protected on external supply). Write-block, output-float and input-ignore are high. Backup-select, backup-armed and data-lost are low.
- R2: With grade_tight=1, protection is entered at readings of 4500 mV or less and normal operation resumes above 4750 mV. With grade_tight=0 the two levels are 4250 mV and 4500 mV.
- R3: In state 0 (normal) a reading between the protect and resume levels keeps the state at 0. In state 1 such a reading keeps the state at 1, so normal operation resumes only above the resume level.
- R4: wr_block, out_hiz and in_ignore are all high in every state except 0 and all low in state 0. No input can clear them while protected.
- R5: When armed, a qualified reading below 3000 mV moves the state to 2 (protected on backup) and raises on_backup. From state 2, a qualified reading above 3000 mV returns the state to 1. In state 0, the below-3000 condition takes priority over the protect condition.
- R6: backup_armed rises on the first valid reading above 4250 mV and stays high until reset.
- R7: When not armed, a qualified reading below 3000 mV leaves on_backup low and the state at 1, and sets data_lost. data_lost then stays high until reset.
- R8: A condition acts only on the qual_len-th consecutive valid sample that meets it, and a qual_len of 0 acts as 1. A valid sample that fails the condition restarts its run. Run counters saturate at their maximum.
- R9: A cycle with sample_valid low changes no output and neither extends nor breaks any run.
- R10: A valid sample presented before a clock edge takes effect on the registered outputs at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | supply_mv carries a new reading this cycle |
| supply_mv | input | MV_W | Supply reading in millivolts |
| grade_tight | input | 1 | 1 selects the tight tolerance grade, 0 the wide one |
| qual_len | input | QUAL_W | Consecutive samples needed to act on a condition |
| wr_block | output | 1 | Writes are blocked |
| out_hiz | output | 1 | Data drivers must float |
| in_ignore | output | 1 | Access inputs are don't-care |
| on_backup | output | 1 | Array is fed from the backup cell |
| backup_armed | output | 1 | Backup cell has been unsealed |
| data_lost | output | 1 | Supply collapsed while the cell was still sealed |
| state_code | output | 2 | 0 normal, 1 protected on external, 2 protected on backup |

## Verification
The bench builds the block with QUAL_W=3 and the default millivolt levels. The narrow counter lets random runs reach counter saturation, a run length of zero and the largest run length of seven within a few hundred samples. Readings are drawn mostly from narrow windows around 3000, 4250, 4500 and 4750 mV, so that exact-boundary values and runs broken by a single sample occur often under both grades. A mid-run reset followed by a collapse before any arming reading exercises the sealed path.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_HOLD_EXT = 2'd1,
        ST_HOLD_BAT = 2'd2
    } guard_state_e;

    typedef struct packed {
        guard_state_e state;
        logic         armed;
        logic         lost;
    } guard_regs_t;

    localparam int unsigned COND_LOW  = 0;
    localparam int unsigned COND_HIGH = 1;
    localparam int unsigned COND_DOWN = 2;
    localparam int unsigned COND_UP   = 3;
    localparam int unsigned COND_NUM  = 4;

endpackage

// File: rtl/supply_limits.sv
module supply_limits #(
    parameter int unsigned MV_W          = 16,
    parameter int unsigned TIGHT_RUN_MV  = 4750,
    parameter int unsigned TIGHT_PROT_MV = 4500,
    parameter int unsigned WIDE_RUN_MV   = 4500,
    parameter int unsigned WIDE_PROT_MV  = 4250
) (
    input  logic            grade_tight,
    output logic [MV_W-1:0] run_mv,
    output logic [MV_W-1:0] prot_mv
);
    always_comb begin
        if (grade_tight) begin
            run_mv  = MV_W'(TIGHT_RUN_MV);
            prot_mv = MV_W'(TIGHT_PROT_MV);
        end else begin
            run_mv  = MV_W'(WIDE_RUN_MV);
            prot_mv = MV_W'(WIDE_PROT_MV);
        end
    end
endmodule

// File: rtl/supply_qualifier.sv
module supply_qualifier #(
    parameter int unsigned QUAL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic              cond,
    input  logic [QUAL_W-1:0] qual_len,
    output logic              hit
);
    localparam logic [QUAL_W-1:0] RUN_MAX = {QUAL_W{1'b1}};

    logic [QUAL_W-1:0] run_d, run_q;
    logic [QUAL_W:0]   run_next;
    logic [QUAL_W:0]   need;

    always_comb begin
        run_next = {1'b0, run_q} + 1'b1;
        need     = (qual_len == '0) ? {{QUAL_W{1'b0}}, 1'b1} : {1'b0, qual_len};
        hit      = sample_valid && cond && (run_next >= need);
        run_d    = run_q;
        if (sample_valid) begin
            if (!cond)
                run_d = '0;
            else if (run_q != RUN_MAX)
                run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else
            run_q <= run_d;
    end
endmodule

// File: rtl/supply_guard.sv
module supply_guard
    import supply_guard_pkg::*;
#(
    parameter int unsigned MV_W          = 16,
    parameter int unsigned QUAL_W        = 4,
    parameter int unsigned TIGHT_RUN_MV  = 4750,
    parameter int unsigned TIGHT_PROT_MV = 4500,
    parameter int unsigned WIDE_RUN_MV   = 4500,
    parameter int unsigned WIDE_PROT_MV  = 4250,
    parameter int unsigned SWITCH_MV     = 3000,
    parameter int unsigned ARM_MV        = 4250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [MV_W-1:0]   supply_mv,
    input  logic              grade_tight,
    input  logic [QUAL_W-1:0] qual_len,
    output logic              wr_block,
    output logic              out_hiz,
    output logic              in_ignore,
    output logic              on_backup,
    output logic              backup_armed,
    output logic              data_lost,
    output logic [1:0]        state_code
);
    localparam logic [MV_W-1:0] SWITCH_LVL = MV_W'(SWITCH_MV);
    localparam logic [MV_W-1:0] ARM_LVL    = MV_W'(ARM_MV);

    logic [MV_W-1:0]     run_mv, prot_mv;
    logic [COND_NUM-1:0] cond, hit;
    guard_regs_t         regs_d, regs_q;

    supply_limits #(
        .MV_W         (MV_W),
        .TIGHT_RUN_MV (TIGHT_RUN_MV),
        .TIGHT_PROT_MV(TIGHT_PROT_MV),
        .WIDE_RUN_MV  (WIDE_RUN_MV),
        .WIDE_PROT_MV (WIDE_PROT_MV)
    ) u_limits (
        .grade_tight(grade_tight),
        .run_mv     (run_mv),
        .prot_mv    (prot_mv)
    );

    always_comb begin
        cond            = '0;
        cond[COND_LOW]  = supply_mv <= prot_mv;
        cond[COND_HIGH] = supply_mv >  run_mv;
        cond[COND_DOWN] = supply_mv <  SWITCH_LVL;
        cond[COND_UP]   = supply_mv >  SWITCH_LVL;
    end

    for (genvar g = 0; g < COND_NUM; g++) begin : g_qual
        supply_qualifier #(.QUAL_W(QUAL_W)) u_qual (
            .clk         (clk),
            .rst_n       (rst_n),
            .sample_valid(sample_valid),
            .cond        (cond[g]),
            .qual_len    (qual_len),
            .hit         (hit[g])
        );
    end

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            ST_RUN: begin
                if (hit[COND_DOWN]) begin
                    if (regs_q.armed) begin
                        regs_d.state = ST_HOLD_BAT;
                    end else begin
                        regs_d.state = ST_HOLD_EXT;
                        regs_d.lost  = 1'b1;
                    end
                end else if (hit[COND_LOW]) begin
                    regs_d.state = ST_HOLD_EXT;
                end
            end
            ST_HOLD_EXT: begin
                if (hit[COND_DOWN]) begin
                    if (regs_q.armed)
                        regs_d.state = ST_HOLD_BAT;
                    else
                        regs_d.lost = 1'b1;
                end else if (hit[COND_HIGH]) begin
                    regs_d.state = ST_RUN;
                end
            end
            ST_HOLD_BAT: begin
                if (hit[COND_UP])
                    regs_d.state = ST_HOLD_EXT;
            end
            default: regs_d.state = ST_HOLD_EXT;
        endcase
        if (sample_valid && (supply_mv > ARM_LVL))
            regs_d.armed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.state <= ST_HOLD_EXT;
            regs_q.armed <= 1'b0;
            regs_q.lost  <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        wr_block     = regs_q.state != ST_RUN;
        out_hiz      = regs_q.state != ST_RUN;
        in_ignore    = regs_q.state != ST_RUN;
        on_backup    = regs_q.state == ST_HOLD_BAT;
        backup_armed = regs_q.armed;
        data_lost    = regs_q.lost;
        state_code   = regs_q.state;
    end
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk #(
    parameter int unsigned MV_W          = 16,
    parameter int unsigned TIGHT_RUN_MV  = 4750,
    parameter int unsigned WIDE_RUN_MV   = 4500,
    parameter int unsigned SWITCH_MV     = 3000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sample_valid,
    input logic [MV_W-1:0] supply_mv,
    input logic            grade_tight,
    input logic            on_backup,
    input logic            backup_armed,
    input logic            data_lost,
    input logic [1:0]      state_code
);
    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code != 2'd3);

    // R5
    bat_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        on_backup |-> backup_armed);

    // R5
    bat_entry_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd2 && $past(state_code) != 2'd2) |-> ($past(supply_mv) < MV_W'(SWITCH_MV)));

    // R6
    arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        backup_armed |=> backup_armed);

    // R7
    lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_lost |=> data_lost);

    // R7
    lost_no_bat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_lost) |-> (!on_backup && !$past(backup_armed)));

    // R3
    resume_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd0 && $past(state_code) != 2'd0) |->
            ($past(supply_mv) > ($past(grade_tight) ? MV_W'(TIGHT_RUN_MV) : MV_W'(WIDE_RUN_MV))));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> ($stable(state_code) && $stable(backup_armed) && $stable(data_lost)));
endmodule

bind supply_guard supply_guard_chk #(
    .MV_W        (MV_W),
    .TIGHT_RUN_MV(TIGHT_RUN_MV),
    .WIDE_RUN_MV (WIDE_RUN_MV),
    .SWITCH_MV   (SWITCH_MV)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_valid(sample_valid),
    .supply_mv   (supply_mv),
    .grade_tight (grade_tight),
    .on_backup   (on_backup),
    .backup_armed(backup_armed),
    .data_lost   (data_lost),
    .state_code  (state_code)
);

// File: tb/supply_guard_bench.sv
module supply_guard_bench;
    localparam int MV_W   = 16;
    localparam int QUAL_W = 3;
    localparam int RMAX   = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_valid = 1'b0;
    logic [MV_W-1:0]   supply_mv = '0;
    logic              grade_tight = 1'b0;
    logic [QUAL_W-1:0] qual_len = '0;
    logic wr_block, out_hiz, in_ignore, on_backup, backup_armed, data_lost;
    logic [1:0] state_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_st, m_arm, m_lost;
    int m_run[4];

    always #4 clk = ~clk;

    supply_guard #(.MV_W(MV_W), .QUAL_W(QUAL_W)) u_supply_guard (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .supply_mv(supply_mv),
        .grade_tight(grade_tight), .qual_len(qual_len), .wr_block(wr_block),
        .out_hiz(out_hiz), .in_ignore(in_ignore), .on_backup(on_backup),
        .backup_armed(backup_armed), .data_lost(data_lost), .state_code(state_code)
    );

    function automatic bit cond_of(int k, int mv, bit tight);
        int runl = tight ? 4750 : 4500;
        int prot = tight ? 4500 : 4250;
        case (k)
            0: return mv <= prot;
            1: return mv > runl;
            2: return mv < 3000;
            default: return mv > 3000;
        endcase
    endfunction

    function automatic void model_reset();
        m_st = 1; m_arm = 0; m_lost = 0;
        for (int k = 0; k < 4; k++) m_run[k] = 0;
    endfunction

    function automatic void model_step(bit v, int mv, bit tight, int len);
        bit h[4];
        int need = (len == 0) ? 1 : len;
        for (int k = 0; k < 4; k++) begin
            bit c = cond_of(k, mv, tight);
            h[k] = v && c && (m_run[k] + 1 >= need);
            if (v) m_run[k] = c ? ((m_run[k] < RMAX) ? m_run[k] + 1 : RMAX) : 0;
        end
        case (m_st)
            0: if (h[2]) begin
                   if (m_arm) m_st = 2; else begin m_st = 1; m_lost = 1; end
               end else if (h[0]) m_st = 1;
            1: if (h[2]) begin
                   if (m_arm) m_st = 2; else m_lost = 1;
               end else if (h[1]) m_st = 0;
            default: if (h[3]) m_st = 1;
        endcase
        if (v && mv > 4250) m_arm = 1;
    endfunction

    task automatic check_all(string req);
        int exp_prot = (m_st != 0);
        checks++;
        if (state_code !== 2'(m_st) || wr_block !== 1'(exp_prot) || out_hiz !== 1'(exp_prot) ||
            in_ignore !== 1'(exp_prot) || on_backup !== 1'(m_st == 2) ||
            backup_armed !== 1'(m_arm) || data_lost !== 1'(m_lost)) begin
            errors++;
            $display("FAIL %s: actual st=%0d wb=%0b hz=%0b ig=%0b bat=%0b arm=%0b lost=%0b expected st=%0d prot=%0d bat=%0d arm=%0d lost=%0d",
                     req, state_code, wr_block, out_hiz, in_ignore, on_backup, backup_armed, data_lost,
                     m_st, exp_prot, m_st == 2, m_arm, m_lost);
        end
    endtask

    task automatic expect_code(string req, int exp);
        checks++;
        if (state_code !== 2'(exp)) begin
            errors++;
            $display("FAIL %s: actual state=%0d expected state=%0d", req, state_code, exp);
        end
    endtask

    task automatic step(bit v, int mv, string req);
        sample_valid = v;
        supply_mv = MV_W'(mv);
        @(posedge clk);
        model_step(v, mv, grade_tight, int'(qual_len));
        @(negedge clk);
        check_all(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sample_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        do_reset();
        check_all("R1 reset");
        expect_code("R1 reset code", 1);

        // wide grade, single-sample qualification
        grade_tight = 0; qual_len = 1;
        step(1, 4250, "R6 not above arm level");
        step(1, 4251, "R6 arm");
        step(1, 4500, "R2 wide at resume level stays protected");
        expect_code("R2 wide 4500", 1);
        step(1, 4501, "R2 R10 wide resume");
        expect_code("R10 resume same edge", 0);
        step(1, 4300, "R3 hysteresis keeps normal");
        step(1, 4251, "R3 hysteresis keeps normal");
        step(1, 4250, "R2 R4 wide protect at 4250");
        expect_code("R4 protected", 1);
        step(1, 4400, "R3 hysteresis keeps protected");
        step(0, 5000, "R9 invalid ignored");
        expect_code("R9 invalid", 1);

        // tight grade
        grade_tight = 1;
        step(1, 4750, "R2 tight at resume level");
        step(1, 4751, "R2 tight resume");
        step(1, 4501, "R3 tight hysteresis");
        step(1, 4500, "R2 tight protect");

        // backup switching
        step(1, 3000, "R5 at switch level stays external");
        step(1, 2999, "R5 to backup");
        expect_code("R5 backup code", 2);
        step(1, 3000, "R5 at switch level stays backup");
        step(1, 3001, "R5 back to external");
        expect_code("R5 external code", 1);

        // qualification
        qual_len = 3;
        step(1, 5000, "R8 run 1");
        step(0, 100,  "R9 invalid inside run");
        step(1, 5000, "R8 run 2");
        step(1, 4000, "R8 broken run");
        step(1, 5000, "R8 run 1 again");
        step(1, 5000, "R8 run 2 again");
        expect_code("R8 not yet", 1);
        step(1, 5000, "R8 run 3 resumes");
        expect_code("R8 resumed", 0);
        qual_len = 0;
        step(1, 2000, "R8 zero length acts as one");
        expect_code("R8 zero length to backup", 2);

        // sealed collapse
        do_reset();
        grade_tight = 0; qual_len = 1;
        step(1, 2500, "R7 sealed collapse");
        expect_code("R7 stays external", 1);
        step(1, 3500, "R7 lost sticky");
        step(1, 4600, "R7 lost sticky after arming");

        // random
        for (int i = 0; i < 4000; i++) begin
            int sel = $urandom_range(0, 5);
            int mv;
            case (sel)
                0: mv = $urandom_range(2990, 3010);
                1: mv = $urandom_range(4240, 4260);
                2: mv = $urandom_range(4490, 4510);
                3: mv = $urandom_range(4740, 4760);
                4: mv = $urandom_range(2000, 5200);
                default: mv = $urandom_range(0, 6000);
            endcase
            if (i % 150 == 0) qual_len = QUAL_W'($urandom_range(0, RMAX));
            if (i % 97 == 0) grade_tight = 1'($urandom_range(0, 1));
            if (i == 2000) do_reset();
            step($urandom_range(0, 9) < 8, mv, "R2 R3 R5 R8 random");
        end
        finish_run();
    end
endmodule